// File: doc/BRIEF.md
# Composite Accelerator Request Router

This block sits behind a single accelerator identity as seen by the core and spreads the traffic it receives over several subordinate accelerators. Each incoming request carries a function ID. A translation table that can be rewritten at run time turns that ID into a private subordinate index. The router then relays the request to that subordinate over a valid/ready channel, collects the subordinate's result and hands it back upstream with an OK status.

A function ID whose table entry holds no valid mapping is answered by the router itself with a bad-function status. No subordinate is touched in that case. Only one request is in flight at a time. A table update that would move the entry of the in-flight function is refused, so a transaction always completes on the unit it was steered to.

Top module: `acc_router`

## Requirements
- R1: After reset the router is ready for a request (`up_req_ready`=1), presents no response, drives no subordinate request, and every table entry is invalid, so any function ID is unconfigured.
- R2: A request whose function ID has a valid entry is presented to exactly the mapped subordinate index. The function ID and both operands are passed through unchanged, and each such request activates that subordinate exactly once.
- R3: The result a subordinate returns is delivered upstream unchanged with status 2'b00 (OK); the status never takes a value above 2'b01.
- R4: A request whose function ID has an invalid entry is answered with status 2'b01 (bad function) and data 0. `up_rsp_valid` rises in the cycle right after acceptance, and no subordinate request is raised.
- R5: `up_req_ready` is low from the cycle after a request is accepted until the upstream response handshake has completed.
- R6: While `up_rsp_valid` is high and `up_rsp_ready` is low, the response stays valid with stable data and status.
- R7: A table write (`cfg_wr_en`) to a function ID not in flight is accepted (`cfg_wr_ok`=1) and governs later requests. Writing `cfg_wr_valid`=0 unmaps the ID.
- R8: A table write to the function ID of the request in flight is refused (`cfg_wr_ok`=0), and the old mapping stays in force for later requests.
- R9: A table write in the same cycle as the acceptance of a request for the same function ID is accepted. The accepted request uses the mapping from before the write, and later requests use the new one.
- R10: A subordinate request stays asserted until that subordinate signals ready. The response-ready is offered only to the selected subordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Router can accept a request |
| up_req_func | input | FUNC_W | Function ID of the request |
| up_req_op_a | input | DATA_W | First operand |
| up_req_op_b | input | DATA_W | Second operand |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream consumer takes the response |
| up_rsp_data | output | DATA_W | Response result |
| up_rsp_status | output | 2 | 0 OK, 1 bad function ID |
| dn_req_valid | output | NSUB | Per-subordinate request valid |
| dn_req_ready | input | NSUB | Per-subordinate request ready |
| dn_req_func | output | FUNC_W | Function ID sent to subordinates |
| dn_req_op_a | output | DATA_W | First operand to subordinates |
| dn_req_op_b | output | DATA_W | Second operand to subordinates |
| dn_rsp_valid | input | NSUB | Per-subordinate response valid |
| dn_rsp_ready | output | NSUB | Per-subordinate response ready |
| dn_rsp_data | input | NSUB*DATA_W | Subordinate results, unit i in slice i |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_func | input | FUNC_W | Entry to write |
| cfg_wr_valid | input | 1 | New valid bit of the entry |
| cfg_wr_sub | input | SUB_W | New subordinate index of the entry |
| cfg_wr_ok | output | 1 | The write in this cycle is taken |

## Verification
Two functions of the router can meet in one cycle: a table update and the acceptance of a request, possibly for the same function ID. The bench provokes this in two ways. It drives a write together with a fresh request for the same ID while idle, and it issues a write for the in-flight ID while a slow subordinate is still busy. The result is judged by which subordinate's tagged result comes back, by per-subordinate activation counts, and by the `cfg_wr_ok` value sampled in that cycle.

// File: rtl/acc_router_pkg.sv
package acc_router_pkg;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_BAD_FUNC = 2'd1
  } rsp_status_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DISPATCH,
    ST_WAIT,
    ST_RESPOND
  } route_state_e;

  // A table write clashes when it names the function currently in flight.
  function automatic logic wr_clash(input logic busy, input logic [31:0] wr_f,
                                    input logic [31:0] live_f);
    return busy && (wr_f == live_f);
  endfunction

  // An entry is usable when valid and pointing at an existing subordinate.
  function automatic logic entry_usable(input logic v, input int unsigned sub,
                                        input int unsigned nsub);
    return v && (sub < nsub);
  endfunction

endpackage

// File: rtl/acc_router_xlat.sv
module acc_router_xlat
  import acc_router_pkg::*;
#(
  parameter int FUNC_W = 4,
  parameter int NSUB   = 4,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FUNC_W-1:0] lk_func,
  output logic              lk_hit,
  output logic [SUB_W-1:0]  lk_sub,
  input  logic              wr_en,
  input  logic [FUNC_W-1:0] wr_func,
  input  logic              wr_valid,
  input  logic [SUB_W-1:0]  wr_sub,
  input  logic              lock_en,
  input  logic [FUNC_W-1:0] lock_func,
  output logic              wr_ok
);
  localparam int NENT = 1 << FUNC_W;

  logic             ent_v [NENT];
  logic [SUB_W-1:0] ent_s [NENT];

  assign wr_ok = wr_en && !wr_clash(lock_en, 32'(wr_func), 32'(lock_func));

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[e] <= 1'b0;
        ent_s[e] <= '0;
      end else if (wr_ok && wr_func == FUNC_W'(e)) begin
        ent_v[e] <= wr_valid;
        ent_s[e] <= wr_sub;
      end
    end
  end

  assign lk_hit = entry_usable(ent_v[lk_func], 32'(ent_s[lk_func]), NSUB);
  assign lk_sub = ent_s[lk_func];
endmodule

// File: rtl/acc_router_ctrl.sv
module acc_router_ctrl
  import acc_router_pkg::*;
#(
  parameter int FUNC_W = 4,
  parameter int DATA_W = 32,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [FUNC_W-1:0] up_req_func,
  input  logic [DATA_W-1:0] up_req_op_a,
  input  logic [DATA_W-1:0] up_req_op_b,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_data,
  output logic [1:0]        up_rsp_status,
  input  logic              lk_hit,
  input  logic [SUB_W-1:0]  lk_sub,
  output logic              sel_req_valid,
  input  logic              sel_req_ready,
  input  logic              sel_rsp_valid,
  output logic              sel_rsp_ready,
  input  logic [DATA_W-1:0] sel_rsp_data,
  output logic [SUB_W-1:0]  cur_sub,
  output logic [FUNC_W-1:0] cur_func,
  output logic [DATA_W-1:0] cur_op_a,
  output logic [DATA_W-1:0] cur_op_b,
  output logic              busy,
  output logic              evt_accept
);
  route_state_e      state;
  logic [DATA_W-1:0] rsp_data_q;
  logic [1:0]        rsp_stat_q;

  assign up_req_ready  = (state == ST_IDLE);
  assign evt_accept    = up_req_ready && up_req_valid;
  assign busy          = (state != ST_IDLE);
  assign sel_req_valid = (state == ST_DISPATCH);
  assign sel_rsp_ready = (state == ST_WAIT);
  assign up_rsp_valid  = (state == ST_RESPOND);
  assign up_rsp_data   = rsp_data_q;
  assign up_rsp_status = rsp_stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_sub    <= '0;
      cur_func   <= '0;
      cur_op_a   <= '0;
      cur_op_b   <= '0;
      rsp_data_q <= '0;
      rsp_stat_q <= RSP_OK;
    end else begin
      unique case (state)
        ST_IDLE: if (evt_accept) begin
          cur_func <= up_req_func;
          cur_op_a <= up_req_op_a;
          cur_op_b <= up_req_op_b;
          cur_sub  <= lk_sub;
          if (lk_hit) begin
            rsp_stat_q <= RSP_OK;
            state      <= ST_DISPATCH;
          end else begin
            rsp_stat_q <= RSP_BAD_FUNC;
            rsp_data_q <= '0;
            state      <= ST_RESPOND;
          end
        end
        ST_DISPATCH: if (sel_req_ready) state <= ST_WAIT;
        ST_WAIT: if (sel_rsp_valid) begin
          rsp_data_q <= sel_rsp_data;
          state      <= ST_RESPOND;
        end
        ST_RESPOND: if (up_rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acc_router_steer.sv
module acc_router_steer #(
  parameter int NSUB   = 4,
  parameter int SUB_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic [SUB_W-1:0]       cur_sub,
  input  logic                   sel_req_valid,
  output logic                   sel_req_ready,
  output logic                   sel_rsp_valid,
  input  logic                   sel_rsp_ready,
  output logic [DATA_W-1:0]      sel_rsp_data,
  output logic [NSUB-1:0]        dn_req_valid,
  input  logic [NSUB-1:0]        dn_req_ready,
  input  logic [NSUB-1:0]        dn_rsp_valid,
  output logic [NSUB-1:0]        dn_rsp_ready,
  input  logic [NSUB*DATA_W-1:0] dn_rsp_data
);
  logic [NSUB-1:0] hit;

  for (genvar i = 0; i < NSUB; i++) begin : g_lane
    assign hit[i]          = (cur_sub == SUB_W'(i));
    assign dn_req_valid[i] = sel_req_valid && hit[i];
    assign dn_rsp_ready[i] = sel_rsp_ready && hit[i];
  end

  always_comb begin
    sel_req_ready = 1'b0;
    sel_rsp_valid = 1'b0;
    sel_rsp_data  = '0;
    for (int i = 0; i < NSUB; i++) begin
      if (hit[i]) begin
        sel_req_ready = dn_req_ready[i];
        sel_rsp_valid = dn_rsp_valid[i];
        sel_rsp_data  = dn_rsp_data[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/acc_router.sv
module acc_router #(
  parameter int FUNC_W = 4,
  parameter int DATA_W = 32,
  parameter int NSUB   = 4,
  localparam int SUB_W = (NSUB > 1) ? $clog2(NSUB) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   up_req_valid,
  output logic                   up_req_ready,
  input  logic [FUNC_W-1:0]      up_req_func,
  input  logic [DATA_W-1:0]      up_req_op_a,
  input  logic [DATA_W-1:0]      up_req_op_b,
  output logic                   up_rsp_valid,
  input  logic                   up_rsp_ready,
  output logic [DATA_W-1:0]      up_rsp_data,
  output logic [1:0]             up_rsp_status,
  output logic [NSUB-1:0]        dn_req_valid,
  input  logic [NSUB-1:0]        dn_req_ready,
  output logic [FUNC_W-1:0]      dn_req_func,
  output logic [DATA_W-1:0]      dn_req_op_a,
  output logic [DATA_W-1:0]      dn_req_op_b,
  input  logic [NSUB-1:0]        dn_rsp_valid,
  output logic [NSUB-1:0]        dn_rsp_ready,
  input  logic [NSUB*DATA_W-1:0] dn_rsp_data,
  input  logic                   cfg_wr_en,
  input  logic [FUNC_W-1:0]      cfg_wr_func,
  input  logic                   cfg_wr_valid,
  input  logic [SUB_W-1:0]       cfg_wr_sub,
  output logic                   cfg_wr_ok
);
  logic              lk_hit;
  logic [SUB_W-1:0]  lk_sub;
  logic              sel_req_valid, sel_req_ready, sel_rsp_valid, sel_rsp_ready;
  logic [DATA_W-1:0] sel_rsp_data;
  logic [SUB_W-1:0]  cur_sub;
  logic              busy;
  // named events for the checker
  logic              evt_accept;
  logic              evt_miss;

  assign evt_miss = evt_accept && !lk_hit;

  acc_router_xlat #(.FUNC_W(FUNC_W), .NSUB(NSUB), .SUB_W(SUB_W)) xlat_i (
    .clk, .rst_n,
    .lk_func(up_req_func), .lk_hit, .lk_sub,
    .wr_en(cfg_wr_en), .wr_func(cfg_wr_func), .wr_valid(cfg_wr_valid),
    .wr_sub(cfg_wr_sub), .lock_en(busy), .lock_func(dn_req_func),
    .wr_ok(cfg_wr_ok)
  );

  acc_router_ctrl #(.FUNC_W(FUNC_W), .DATA_W(DATA_W), .SUB_W(SUB_W)) ctrl_i (
    .clk, .rst_n,
    .up_req_valid, .up_req_ready, .up_req_func, .up_req_op_a, .up_req_op_b,
    .up_rsp_valid, .up_rsp_ready, .up_rsp_data, .up_rsp_status,
    .lk_hit, .lk_sub,
    .sel_req_valid, .sel_req_ready, .sel_rsp_valid, .sel_rsp_ready, .sel_rsp_data,
    .cur_sub, .cur_func(dn_req_func), .cur_op_a(dn_req_op_a), .cur_op_b(dn_req_op_b),
    .busy, .evt_accept
  );

  acc_router_steer #(.NSUB(NSUB), .SUB_W(SUB_W), .DATA_W(DATA_W)) steer_i (
    .cur_sub, .sel_req_valid, .sel_req_ready, .sel_rsp_valid, .sel_rsp_ready,
    .sel_rsp_data, .dn_req_valid, .dn_req_ready, .dn_rsp_valid, .dn_rsp_ready,
    .dn_rsp_data
  );
endmodule

// File: rtl/acc_router_chk.sv
module acc_router_chk #(
  parameter int FUNC_W = 4,
  parameter int DATA_W = 32,
  parameter int NSUB   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic [FUNC_W-1:0] up_req_func,
  input logic              up_rsp_valid,
  input logic              up_rsp_ready,
  input logic [DATA_W-1:0] up_rsp_data,
  input logic [1:0]        up_rsp_status,
  input logic [NSUB-1:0]   dn_req_valid,
  input logic [NSUB-1:0]   dn_req_ready,
  input logic [NSUB-1:0]   dn_rsp_ready,
  input logic              cfg_wr_en,
  input logic [FUNC_W-1:0] cfg_wr_func,
  input logic              cfg_wr_ok,
  input logic              evt_miss
);
  logic [FUNC_W-1:0] live_f;
  always_ff @(posedge clk) begin
    if (!rst_n) live_f <= '0;
    else if (up_req_valid && up_req_ready) live_f <= up_req_func;
  end

  p_dn_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_req_valid) && $onehot0(dn_rsp_ready));

  p_status_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> (up_rsp_status <= 2'd1));

  p_miss_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_miss |=> (up_rsp_valid && up_rsp_status == 2'd1 && up_rsp_data == '0
                  && dn_req_valid == '0));

  p_single_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && up_req_ready) |=> !up_req_ready);

  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=>
      (up_rsp_valid && $stable(up_rsp_data) && $stable(up_rsp_status)));

  p_live_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !up_req_ready && cfg_wr_func == live_f) |-> !cfg_wr_ok);

  p_idle_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && up_req_ready) |-> cfg_wr_ok);

  p_dn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_req_valid & ~dn_req_ready) != '0) |=> $stable(dn_req_valid));
endmodule

bind acc_router acc_router_chk #(.FUNC_W(FUNC_W), .DATA_W(DATA_W), .NSUB(NSUB)) chk_i (
  .clk, .rst_n, .up_req_valid, .up_req_ready, .up_req_func, .up_rsp_valid,
  .up_rsp_ready, .up_rsp_data, .up_rsp_status, .dn_req_valid, .dn_req_ready,
  .dn_rsp_ready, .cfg_wr_en, .cfg_wr_func, .cfg_wr_ok, .evt_miss
);

// File: tb/acc_router_tb_top.sv
module acc_router_tb_top;
  localparam int FW = 4;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              up_req_valid = 0, up_req_ready;
  logic [FW-1:0]     up_req_func = '0;
  logic [DW-1:0]     up_req_op_a = '0, up_req_op_b = '0;
  logic              up_rsp_valid, up_rsp_ready = 1'b1;
  logic [DW-1:0]     up_rsp_data;
  logic [1:0]        up_rsp_status;
  logic [NS-1:0]     dn_req_valid, dn_req_ready, dn_rsp_valid, dn_rsp_ready;
  logic [FW-1:0]     dn_req_func;
  logic [DW-1:0]     dn_req_op_a, dn_req_op_b;
  logic [NS*DW-1:0]  dn_rsp_data;
  logic              cfg_wr_en = 0, cfg_wr_valid = 0, cfg_wr_ok;
  logic [FW-1:0]     cfg_wr_func = '0;
  logic [SW-1:0]     cfg_wr_sub = '0;

  acc_router #(.FUNC_W(FW), .DATA_W(DW), .NSUB(NS)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // subordinate result: tagged with its index in the top byte
  function automatic logic [DW-1:0] sub_res(input int i, input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {8'(i + 8'hA0), 24'((a ^ b) + 24'h000111)};
  endfunction

  // subordinate models, unit i waits i cycles before ready and before answering
  int stg[NS], cnt[NS], act[NS], exp_act[NS];
  logic [DW-1:0] res[NS];
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      dn_req_ready[i] = (stg[i] == 1) && (cnt[i] == 0);
      dn_rsp_valid[i] = (stg[i] == 2) && (cnt[i] == 0);
      dn_rsp_data[i*DW +: DW] = res[i];
    end
  end
  always @(posedge clk) begin
    for (int i = 0; i < NS; i++) begin
      if (!rst_n) begin
        stg[i] <= 0; cnt[i] <= 0; res[i] <= '0;
      end else case (stg[i])
        0: if (dn_req_valid[i]) begin stg[i] <= 1; cnt[i] <= i; end
        1: if (cnt[i] != 0) cnt[i] <= cnt[i] - 1;
           else if (dn_req_valid[i]) begin
             res[i] <= sub_res(i, dn_req_op_a, dn_req_op_b);
             act[i] <= act[i] + 1;
             stg[i] <= 2; cnt[i] <= i;
           end
        default: if (cnt[i] != 0) cnt[i] <= cnt[i] - 1;
                 else if (dn_rsp_ready[i]) stg[i] <= 0;
      endcase
    end
  end

  // upstream back-pressure
  bit bp = 0;
  always @(posedge clk) begin
    #1 up_rsp_ready = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // shadow table and scoreboard
  bit sh_v[16];
  int sh_s[16];
  logic [33:0] exp_q[$];
  string tag_q[$];

  logic hold_prev = 0;
  logic [33:0] prev_rsp = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev)
        chk(up_rsp_valid && {up_rsp_status, up_rsp_data} == prev_rsp, "R6 hold",
            {31'b0, up_rsp_valid, up_rsp_status, up_rsp_data}, {31'b0, 1'b1, prev_rsp});
      if (up_rsp_valid && up_rsp_ready) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected response", 64'(up_rsp_data), 0);
        else begin
          logic [33:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({up_rsp_status, up_rsp_data} == e, t, 64'({up_rsp_status, up_rsp_data}), 64'(e));
        end
      end
      hold_prev = up_rsp_valid && !up_rsp_ready;
      prev_rsp  = {up_rsp_status, up_rsp_data};
    end
  end

  function automatic logic [33:0] expect_of(input int f, input logic [DW-1:0] a, input logic [DW-1:0] b);
    return sh_v[f] ? {2'b00, sub_res(sh_s[f], a, b)} : {2'b01, 32'h0};
  endfunction

  // issue one request; optional same-cycle table write; returns after acceptance
  task automatic send(input int f, input logic [DW-1:0] a, input logic [DW-1:0] b, input string tag,
                      input bit with_wr = 0, input int wsub = 0);
    exp_q.push_back(expect_of(f, a, b));
    tag_q.push_back(tag);
    if (sh_v[f]) exp_act[sh_s[f]]++;
    @(posedge clk); #1;
    up_req_valid = 1; up_req_func = FW'(f); up_req_op_a = a; up_req_op_b = b;
    if (with_wr) begin
      cfg_wr_en = 1; cfg_wr_func = FW'(f); cfg_wr_valid = 1; cfg_wr_sub = SW'(wsub);
    end
    forever begin
      @(negedge clk);
      if (with_wr) chk(cfg_wr_ok == 1'b1, "R9 same-cycle write taken", 64'(cfg_wr_ok), 1);
      if (up_req_ready) break;
    end
    @(posedge clk); #1;
    up_req_valid = 0; cfg_wr_en = 0;
    if (with_wr) begin sh_v[f] = 1; sh_s[f] = wsub; end
  endtask

  task automatic cfg(input int f, input bit v, input int s, input bit exp_ok, input string tag);
    @(posedge clk); #1;
    cfg_wr_en = 1; cfg_wr_func = FW'(f); cfg_wr_valid = v; cfg_wr_sub = SW'(s);
    @(negedge clk);
    chk(cfg_wr_ok == exp_ok, tag, 64'(cfg_wr_ok), 64'(exp_ok));
    @(posedge clk); #1;
    cfg_wr_en = 0;
    if (exp_ok) begin sh_v[f] = v; sh_s[f] = s; end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !up_req_ready) @(negedge clk);
  endtask

  task automatic chk_act(input string tag);
    for (int i = 0; i < NS; i++) chk(act[i] == exp_act[i], tag, 64'(act[i]), 64'(exp_act[i]));
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin act[i] = 0; exp_act[i] = 0; end
    for (int i = 0; i < 16; i++) begin sh_v[i] = 0; sh_s[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(up_req_ready == 1, "R1 ready after reset", 64'(up_req_ready), 1);
    chk(up_rsp_valid == 0, "R1 no response after reset", 64'(up_rsp_valid), 0);
    chk(dn_req_valid == 0, "R1 no sub request after reset", 64'(dn_req_valid), 0);

    // R1/R4: empty table -> bad function, fast, no subordinate
    send(0, 32'h11, 32'h22, "R1 empty table answers bad function");
    @(negedge clk);
    chk(up_rsp_valid && up_rsp_status == 2'd1, "R4 error one cycle after accept",
        64'({up_rsp_valid, up_rsp_status}), 64'({1'b1, 2'd1}));
    chk(up_req_ready == 0, "R5 busy after accept", 64'(up_req_ready), 0);
    chk(dn_req_valid == 0, "R4 no sub request", 64'(dn_req_valid), 0);
    drain();
    chk_act("R4 no activation");

    // R7: populate table
    cfg(2, 1, 0, 1, "R7 write accepted");
    cfg(5, 1, 1, 1, "R7 write accepted");
    cfg(3, 1, 3, 1, "R7 write accepted");
    cfg(7, 1, 2, 1, "R7 write accepted");

    // R2/R3: each mapping
    send(2, 32'h0000_1234, 32'h0000_00FF, "R3 func2 via sub0");
    send(5, 32'hDEAD_BEEF, 32'h1234_5678, "R3 func5 via sub1");
    send(3, 32'h0, 32'hFFFF_FFFF, "R3 func3 via sub3");
    send(7, 32'h5555_AAAA, 32'h0F0F_0F0F, "R3 func7 via sub2");
    drain();
    chk_act("R2 one activation per mapped request");

    // R6/R10: back-pressure and back-to-back traffic
    bp = 1;
    for (int k = 0; k < 12; k++)
      send((k % 3 == 0) ? 2 : (k % 3 == 1) ? 3 : 9, 32'(k * 77), 32'(k ^ 32'h3C), "R6 under back-pressure");
    drain();
    bp = 0;
    chk_act("R10 activations under back-pressure");

    // R7: unmap
    cfg(7, 0, 2, 1, "R7 unmap write accepted");
    send(7, 32'h1, 32'h2, "R7 unmapped now bad function");
    drain();
    chk_act("R4 unmapped no activation");

    // R8: write to in-flight function is refused; other ID taken
    send(3, 32'hAB, 32'hCD, "R8 in-flight request on sub3");
    cfg(3, 1, 0, 0, "R8 in-flight write refused");
    cfg(9, 1, 1, 1, "R7 write to other ID while busy");
    drain();
    send(3, 32'h77, 32'h88, "R8 old mapping kept");
    send(9, 32'h99, 32'h01, "R7 new mapping used");
    drain();
    chk_act("R8 activations");

    // R9: same-cycle write and accept of the same function
    send(5, 32'h4242, 32'h1111, "R9 uses pre-write mapping", 1, 2);
    drain();
    send(5, 32'h4242, 32'h1111, "R9 later request uses new mapping");
    drain();
    chk_act("R9 activations");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule